// File: doc/BRIEF.md
# SCSI Controller Host Register and Interrupt Unit

This block is the byte-wide register file that a host processor sees on a SCSI protocol controller. The host selects one of ten register slots with an index. A write strobe updates the write-side image, and a read strobe triggers the read-side effects. Some slot indices mean different things for a read and for a write. The unit holds a 24-bit transfer counter, which is loaded from a separately written start count. It also keeps the interrupt, status and sequence-step registers and drives an active-high interrupt line. Its own commands are no-op, FIFO flush, chip reset, bus reset, message accepted, enable selection and disable selection.

Selection and transfer commands are not executed here. They are handed to a separate bus sequencer as a one-cycle strobe with the full command byte. The sequencer sends two things back: a terminal-count event and a sequence-step value. A 16-byte data FIFO sits behind the data slot, and its occupancy can be read through the flags slot. Read data is combinational from the index, so the host can look at any slot without changing anything. The clear-on-read and pop actions happen only on the clock edge of a read strobe. The host issues at most one access, read or write, per cycle.

Top module: `scsi_regif`

## Requirements
- R1: After reset the interrupt output is low and the following reads hold: slot 9 (config 1) reads 0x07, slots 0 and 1 read 0, slot 2 reads the chip identity (parameter default 0xA2), and slots 3 to 8 read 0.
- R2: Writes to slots 0, 1 and 2 (count bytes, least significant first) load only the start-count image. Reads of those slots return the live 24-bit counter, which such writes leave unchanged.
- R3: A write to slot 4 (command) with bit 7 set loads the live counter from the start count. If the start count is zero, it loads 0x010000 instead.
- R4: A write to any of slots 0 to 2 clears the terminal-count bit, which is bit 4 of the status register (read slot 5).
- R5: Slot 2 reads the chip identity until slot 2 has been written after the last reset. From then on it reads the high byte of the live counter.
- R6: A read strobe on slot 6 (interrupt register) returns its value, then clears it. It also clears status bits 4 and 7. The interrupt output always equals status bit 7.
- R7: Slot 8 reads the data-FIFO occupancy in bits 4:0. A write to slot 3 pushes a byte, and the push is dropped when 16 bytes are held. A read strobe on slot 3 pops in arrival order, and an empty FIFO reads 0. Command code 0x01 empties the FIFO.
- R8: Command code 0x03 (bus reset) sets interrupt bit 7 and raises the interrupt, unless bit 6 of config 1 is set. In that case it has no effect.
- R9: Command code 0x12 (message accepted) sets interrupt bit 5, clears the sequence step (slot 7, bits 2:0) and raises the interrupt.
- R10: Command code 0x44 clears the interrupt register and leaves the interrupt output unchanged. Command code 0x45 clears the interrupt register and raises the interrupt.
- R11: Command code 0x02 returns every register, the counter, the identity-readback state and the FIFO to the reset state of R1.
- R12: Command codes 0x10, 0x11, 0x41, 0x42 and 0x43, with bit 7 either value, pulse the sequencer strobe for exactly the cycle after the write. The sequencer opcode output carries the last command byte written. No other code pulses the strobe.
- R13: Reading without the read strobe changes nothing. The sequencer's terminal-count event sets status bit 4, and its step-write loads slot 7.
- R14: A write to slot 5 stores a 3-bit target number, which drives the target output. A read of slot 5 still returns the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| rd_en | input | 1 | One-cycle register read strobe (side effects) |
| reg_idx | input | 4 | Register slot index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for reg_idx, combinational |
| irq | output | 1 | Interrupt request, active high |
| seq_go | output | 1 | One-cycle strobe to the bus sequencer |
| seq_op | output | 8 | Last command byte, for the sequencer |
| sel_target | output | 3 | Target number for selection |
| seq_step_we | input | 1 | Sequencer loads the sequence step |
| seq_step | input | 3 | Sequence step value |
| seq_tc_set | input | 1 | Sequencer terminal-count event |

## Verification
Read data is due in the same cycle as the index, before any edge. Every registered effect of a strobe is due right after the edge that samples it, and this covers the interrupt line, the counter, the FIFO, the interrupt register and the target output. The sequencer strobe is high only in the cycle that follows the command write. The bench drives each access at the falling edge and compares the read data one nanosecond later against a behavioural model. It then advances the model at the rising edge and compares the registered outputs at the next falling edge, so each result is sampled in exactly the cycle it becomes due.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;
  // Slot indices: count bytes are least significant first
  localparam logic [3:0] RI_CNT0     = 4'd0;
  localparam logic [3:0] RI_CNT1     = 4'd1;
  localparam logic [3:0] RI_CNT2     = 4'd2;
  localparam logic [3:0] RI_DATA     = 4'd3;
  localparam logic [3:0] RI_CMD      = 4'd4;
  localparam logic [3:0] RI_STAT_TGT = 4'd5;
  localparam logic [3:0] RI_INTR     = 4'd6;
  localparam logic [3:0] RI_STEP     = 4'd7;
  localparam logic [3:0] RI_FLAGS    = 4'd8;
  localparam logic [3:0] RI_CFG1     = 4'd9;

  // Command codes (bit 7 of the command byte is the DMA reload flag)
  localparam logic [6:0] OP_NOP      = 7'h00;
  localparam logic [6:0] OP_FLUSH    = 7'h01;
  localparam logic [6:0] OP_CHIPRST  = 7'h02;
  localparam logic [6:0] OP_BUSRST   = 7'h03;
  localparam logic [6:0] OP_XFER     = 7'h10;
  localparam logic [6:0] OP_FINISH   = 7'h11;
  localparam logic [6:0] OP_MSGOK    = 7'h12;
  localparam logic [6:0] OP_SEL      = 7'h41;
  localparam logic [6:0] OP_SELATN   = 7'h42;
  localparam logic [6:0] OP_SELSTOP  = 7'h43;
  localparam logic [6:0] OP_ENSEL    = 7'h44;
  localparam logic [6:0] OP_DISSEL   = 7'h45;

  localparam int CFG1_NOREPT_BIT  = 6;
  localparam int INTR_BUSRST_BIT  = 7;
  localparam int INTR_DISC_BIT    = 5;
  localparam int STAT_IP_BIT      = 7;
  localparam int STAT_TC_BIT      = 4;
  localparam logic [7:0] CFG1_RESET = 8'h07;

  typedef struct packed {
    logic reload;
    logic flush;
    logic soft_rst;
    logic bus_rst;
    logic msg_ok;
    logic en_sel;
    logic dis_sel;
    logic handoff;
  } cmd_act_t;
endpackage

// File: rtl/scsi_regif_cmd_dec.sv
module scsi_regif_cmd_dec
  import scsi_regif_pkg::*;
(
  input  logic       valid,
  input  logic [7:0] cmd,
  output cmd_act_t   act
);
  always_comb begin
    act = '0;
    if (valid) begin
      act.reload = cmd[7];
      case (cmd[6:0])
        OP_FLUSH:   act.flush    = 1'b1;
        OP_CHIPRST: act.soft_rst = 1'b1;
        OP_BUSRST:  act.bus_rst  = 1'b1;
        OP_MSGOK:   act.msg_ok   = 1'b1;
        OP_ENSEL:   act.en_sel   = 1'b1;
        OP_DISSEL:  act.dis_sel  = 1'b1;
        OP_XFER, OP_FINISH, OP_SEL, OP_SELATN, OP_SELSTOP:
                    act.handoff  = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/scsi_regif_count.sv
module scsi_regif_count #(
  parameter int CNT_W = 24,
  parameter logic [CNT_W-1:0] EMPTY_LOAD = CNT_W'(32'h0001_0000),
  localparam int NB = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NB-1:0]    byte_we,
  input  logic [7:0]       wdata,
  input  logic             reload,
  output logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] start,
  output logic             hi_written
);
  logic [CNT_W-1:0] start_q, start_d, live_q, live_d;
  logic             hiw_q, hiw_d;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign start_d[b*8 +: 8] = clr        ? 8'h00 :
                               byte_we[b] ? wdata : start_q[b*8 +: 8];
  end

  always_comb begin
    live_d = live_q;
    hiw_d  = hiw_q | byte_we[NB-1];
    if (reload) live_d = (start_q == '0) ? EMPTY_LOAD : start_q;
    if (clr) begin
      live_d = '0;
      hiw_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      live_q  <= '0;
      hiw_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      live_q  <= live_d;
      hiw_q   <= hiw_d;
    end
  end

  assign live       = live_q;
  assign start      = start_q;
  assign hi_written = hiw_q;
endmodule

// File: rtl/scsi_regif_fifo.sv
module scsi_regif_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] used
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rp_q, rp_d, wp_q, wp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (cnt_q != CNT_W'(DEPTH)) && !clr;
  assign do_pop  = pop && (cnt_q != '0) && !clr;

  always_comb begin
    rp_d  = do_pop  ? step_ptr(rp_q) : rp_q;
    wp_d  = do_push ? step_ptr(wp_q) : wp_q;
    cnt_d = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    if (clr) begin
      rp_d  = '0;
      wp_d  = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      rp_q  <= rp_d;
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  assign head = (cnt_q != '0) ? mem[rp_q] : '0;
  assign used = cnt_q;
endmodule

// File: rtl/scsi_regif.sv
module scsi_regif
  import scsi_regif_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 24,
  parameter int TGT_W      = 3,
  parameter int STEP_W     = 3,
  parameter logic [7:0] CHIP_ID = 8'hA2,
  parameter logic [CNT_W-1:0] EMPTY_LOAD = CNT_W'(32'h0001_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        reg_idx,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq,
  output logic              seq_go,
  output logic [7:0]        seq_op,
  output logic [TGT_W-1:0]  sel_target,
  input  logic              seq_step_we,
  input  logic [STEP_W-1:0] seq_step,
  input  logic              seq_tc_set
);
  localparam int NB     = CNT_W / 8;
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);

  cmd_act_t          act;
  logic [NB-1:0]     cnt_we;
  logic [CNT_W-1:0]  cnt_live, cnt_start;
  logic              hiw;
  logic [7:0]        fifo_head;
  logic [FCNT_W-1:0] fifo_used;
  logic              wr_cmd, rd_intr;

  logic [7:0]        intr_q, intr_d, cfg_q, cfg_d, cmd_q, cmd_d, stat;
  logic              ip_q, ip_d, tc_q, tc_d, go_q, go_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [TGT_W-1:0]  tgt_q, tgt_d;

  assign wr_cmd  = wr_en && (reg_idx == RI_CMD);
  assign rd_intr = rd_en && (reg_idx == RI_INTR);

  for (genvar b = 0; b < NB; b++) begin : g_cnt_we
    assign cnt_we[b] = wr_en && (int'(reg_idx) == b);
  end

  scsi_regif_cmd_dec u_dec (
    .valid (wr_cmd),
    .cmd   (wdata),
    .act   (act)
  );

  scsi_regif_count #(.CNT_W(CNT_W), .EMPTY_LOAD(EMPTY_LOAD)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (act.soft_rst),
    .byte_we    (cnt_we),
    .wdata      (wdata),
    .reload     (act.reload),
    .live       (cnt_live),
    .start      (cnt_start),
    .hi_written (hiw)
  );

  scsi_regif_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (act.soft_rst || act.flush),
    .push  (wr_en && (reg_idx == RI_DATA)),
    .din   (wdata),
    .pop   (rd_en && (reg_idx == RI_DATA)),
    .head  (fifo_head),
    .used  (fifo_used)
  );

  // Next-state for the control and status registers
  always_comb begin
    intr_d = intr_q;
    ip_d   = ip_q;
    tc_d   = tc_q;
    step_d = step_q;
    cfg_d  = cfg_q;
    cmd_d  = cmd_q;
    tgt_d  = tgt_q;
    go_d   = act.handoff;
    if (wr_cmd) cmd_d = wdata;
    if (wr_en && (reg_idx == RI_CFG1)) cfg_d = wdata;
    if (wr_en && (reg_idx == RI_STAT_TGT)) tgt_d = wdata[TGT_W-1:0];
    if (cnt_we != '0) tc_d = 1'b0;
    if (rd_intr) begin
      intr_d = '0;
      tc_d   = 1'b0;
      ip_d   = 1'b0;
    end
    if (act.bus_rst && !cfg_q[CFG1_NOREPT_BIT]) begin
      intr_d[INTR_BUSRST_BIT] = 1'b1;
      ip_d = 1'b1;
    end
    if (act.msg_ok) begin
      intr_d[INTR_DISC_BIT] = 1'b1;
      step_d = '0;
      ip_d   = 1'b1;
    end
    if (act.en_sel) intr_d = '0;
    if (act.dis_sel) begin
      intr_d = '0;
      ip_d   = 1'b1;
    end
    if (seq_step_we) step_d = seq_step;
    if (seq_tc_set)  tc_d   = 1'b1;
    if (act.soft_rst) begin
      intr_d = '0;
      ip_d   = 1'b0;
      tc_d   = 1'b0;
      step_d = '0;
      cfg_d  = CFG1_RESET;
      cmd_d  = '0;
      tgt_d  = '0;
      go_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr_q <= '0;
      ip_q   <= 1'b0;
      tc_q   <= 1'b0;
      step_q <= '0;
      cfg_q  <= CFG1_RESET;
      cmd_q  <= '0;
      tgt_q  <= '0;
      go_q   <= 1'b0;
    end else begin
      intr_q <= intr_d;
      ip_q   <= ip_d;
      tc_q   <= tc_d;
      step_q <= step_d;
      cfg_q  <= cfg_d;
      cmd_q  <= cmd_d;
      tgt_q  <= tgt_d;
      go_q   <= go_d;
    end
  end

  // Read-side image, combinational from the index
  always_comb begin
    stat = '0;
    stat[STAT_IP_BIT] = ip_q;
    stat[STAT_TC_BIT] = tc_q;
    rdata = '0;
    if (int'(reg_idx) < NB) begin
      if ((int'(reg_idx) == NB - 1) && !hiw) rdata = CHIP_ID;
      else rdata = cnt_live[reg_idx*8 +: 8];
    end else begin
      case (reg_idx)
        RI_DATA:     rdata = fifo_head;
        RI_CMD:      rdata = cmd_q;
        RI_STAT_TGT: rdata = stat;
        RI_INTR:     rdata = intr_q;
        RI_STEP:     rdata = 8'(step_q);
        RI_FLAGS:    rdata = 8'(fifo_used);
        RI_CFG1:     rdata = cfg_q;
        default:     rdata = '0;
      endcase
    end
  end

  assign irq        = ip_q;
  assign seq_go     = go_q;
  assign seq_op     = cmd_q;
  assign sel_target = tgt_q;
endmodule

// File: rtl/scsi_regif_chk.sv
module scsi_regif_chk #(
  parameter int CNT_W = 24,
  parameter int FCNT_W = 5,
  parameter int FIFO_DEPTH = 16,
  parameter logic [7:0] CHIP_ID = 8'hA2,
  parameter logic [CNT_W-1:0] EMPTY_LOAD = CNT_W'(32'h0001_0000)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [3:0]        reg_idx,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              irq,
  input logic              seq_go,
  input logic [CNT_W-1:0]  live,
  input logic [CNT_W-1:0]  start,
  input logic              hiw,
  input logic [FCNT_W-1:0] fifo_used,
  input logic              norept
);
  // R3
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 4'd4 && wdata[7] && wdata[6:0] != 7'h02)
      |=> live == (($past(start) == '0) ? EMPTY_LOAD : $past(start)));

  // R5
  chip_id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hiw && reg_idx == 4'd2) |-> rdata == CHIP_ID);

  // R6
  intr_read_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_idx == 4'd6) |=> !irq);

  // R7
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_used <= FCNT_W'(FIFO_DEPTH));

  // R8
  busrst_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 4'd4 && wdata[6:0] == 7'h03 && !norept) |=> irq);

  // R12
  handoff_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_go |-> $past(wr_en && reg_idx == 4'd4));
endmodule

bind scsi_regif scsi_regif_chk #(
  .CNT_W(CNT_W), .FCNT_W(FCNT_W), .FIFO_DEPTH(FIFO_DEPTH),
  .CHIP_ID(CHIP_ID), .EMPTY_LOAD(EMPTY_LOAD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .reg_idx   (reg_idx),
  .wdata     (wdata),
  .rdata     (rdata),
  .irq       (irq),
  .seq_go    (seq_go),
  .live      (cnt_live),
  .start     (cnt_start),
  .hiw       (hiw),
  .fifo_used (fifo_used),
  .norept    (cfg_q[6])
);

// File: tb/scsi_regif_test.sv
module scsi_regif_test;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, rd_en, seq_step_we, seq_tc_set;
  logic [3:0] reg_idx;
  logic [7:0] wdata, rdata, seq_op;
  logic       irq, seq_go;
  logic [2:0] sel_target, seq_step;

  always #4 clk = ~clk;

  scsi_regif uut (.*);

  localparam logic [7:0] CHIP = 8'hA2;

  int n_chk = 0;
  int n_fail = 0;

  // Behavioural reference state
  int       m_live, m_start;
  bit       m_hiw, m_ip, m_tc, m_go;
  byte      m_q[$];
  bit [7:0] m_intr, m_cfg, m_cmd;
  bit [2:0] m_step, m_tgt;

  task automatic m_clear();
    m_live = 0; m_start = 0; m_hiw = 0; m_ip = 0; m_tc = 0; m_go = 0;
    m_q.delete(); m_intr = 0; m_cfg = 8'h07; m_cmd = 0; m_step = 0; m_tgt = 0;
  endtask

  function automatic logic [7:0] m_read(logic [3:0] a);
    case (a)
      4'd0: return 8'(m_live);
      4'd1: return 8'(m_live >> 8);
      4'd2: return m_hiw ? 8'(m_live >> 16) : CHIP;
      4'd3: return (m_q.size() > 0) ? m_q[0] : 8'h00;
      4'd4: return m_cmd;
      4'd5: return {m_ip, 2'b00, m_tc, 4'b0000};
      4'd6: return m_intr;
      4'd7: return {5'b0, m_step};
      4'd8: return 8'(m_q.size());
      4'd9: return m_cfg;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_edge(bit wr, bit rd, logic [3:0] a, logic [7:0] d,
                        bit swe, logic [2:0] sv, bit tcs);
    bit go_n = 0;
    if (rd && a == 4'd3 && m_q.size() > 0) void'(m_q.pop_front());
    if (rd && a == 4'd6) begin m_intr = 0; m_tc = 0; m_ip = 0; end
    if (wr) begin
      case (a)
        4'd0, 4'd1, 4'd2: begin
          m_start = (m_start & ~(255 << (8 * a))) | (int'(d) << (8 * a));
          m_tc = 0;
          if (a == 4'd2) m_hiw = 1;
        end
        4'd3: if (m_q.size() < 16) m_q.push_back(d);
        4'd4: begin
          if (d[6:0] == 7'h02) m_clear();
          else begin
            m_cmd = d;
            if (d[7]) m_live = (m_start == 0) ? 32'h10000 : m_start;
            case (d[6:0])
              7'h01: m_q.delete();
              7'h03: if (!m_cfg[6]) begin m_intr[7] = 1; m_ip = 1; end
              7'h12: begin m_intr[5] = 1; m_step = 0; m_ip = 1; end
              7'h44: m_intr = 0;
              7'h45: begin m_intr = 0; m_ip = 1; end
              7'h10, 7'h11, 7'h41, 7'h42, 7'h43: go_n = 1;
              default: ;
            endcase
          end
        end
        4'd5: m_tgt = d[2:0];
        4'd9: m_cfg = d;
        default: ;
      endcase
    end
    if (swe) m_step = sv;
    if (tcs) m_tc = 1;
    m_go = go_n;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit wr, bit rd, logic [3:0] a, logic [7:0] d,
                     bit swe = 0, logic [2:0] sv = 0, bit tcs = 0);
    @(negedge clk);
    chk(tag, "irq", int'(irq), int'(m_ip));
    chk(tag, "seq_go", int'(seq_go), int'(m_go));
    chk(tag, "seq_op", int'(seq_op), int'(m_cmd));
    chk(tag, "sel_target", int'(sel_target), int'(m_tgt));
    wr_en = wr; rd_en = rd; reg_idx = a; wdata = d;
    seq_step_we = swe; seq_step = sv; seq_tc_set = tcs;
    #1;
    chk(tag, $sformatf("rdata[%0d]", a), int'(rdata), int'(m_read(a)));
    @(posedge clk);
    m_edge(wr, rd, a, d, swe, sv, tcs);
  endtask

  task automatic wr(string tag, logic [3:0] a, logic [7:0] d);
    cyc(tag, 1, 0, a, d);
  endtask
  task automatic rd(string tag, logic [3:0] a);
    cyc(tag, 0, 1, a, 8'h00);
  endtask
  task automatic peek(string tag, logic [3:0] a);
    cyc(tag, 0, 0, a, 8'h00);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; reg_idx = 0; wdata = 0;
    seq_step_we = 0; seq_step = 0; seq_tc_set = 0;
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state of every slot
    for (int i = 0; i < 10; i++) peek("R1", 4'(i));

    // R5 identity until high byte written; R2 start image versus live counter
    rd("R5", 4'd2);
    wr("R2", 4'd0, 8'h34);
    wr("R2", 4'd1, 8'h12);
    peek("R2", 4'd0);
    peek("R5", 4'd2);
    wr("R5", 4'd2, 8'h00);
    peek("R5", 4'd2);

    // R3 reload, then zero start count
    wr("R3", 4'd4, 8'h80);
    peek("R3", 4'd0);
    peek("R3", 4'd1);
    wr("R3", 4'd0, 8'h00);
    wr("R3", 4'd1, 8'h00);
    wr("R3", 4'd4, 8'h80);
    peek("R3", 4'd2);
    peek("R3", 4'd1);
    peek("R3", 4'd0);

    // R13 sequencer terminal count; R4 cleared by a count write
    cyc("R13", 0, 0, 4'd5, 8'h00, 0, 3'd0, 1);
    peek("R13", 4'd5);
    wr("R4", 4'd1, 8'h07);
    peek("R4", 4'd5);

    // R8 bus reset; R6 clear on read, R13 peeking has no effect
    cyc("R13", 0, 0, 4'd5, 8'h00, 0, 3'd0, 1);
    wr("R8", 4'd4, 8'h03);
    peek("R13", 4'd6);
    peek("R13", 4'd6);
    rd("R6", 4'd6);
    peek("R6", 4'd6);
    peek("R6", 4'd5);
    wr("R8", 4'd9, 8'h47);
    wr("R8", 4'd4, 8'h03);
    peek("R8", 4'd6);
    peek("R8", 4'd5);

    // R9 message accepted; R10 enable/disable selection
    cyc("R13", 0, 0, 4'd7, 8'h00, 1, 3'd5, 0);
    peek("R13", 4'd7);
    wr("R9", 4'd4, 8'h12);
    peek("R9", 4'd6);
    peek("R9", 4'd7);
    wr("R10", 4'd4, 8'h44);
    peek("R10", 4'd6);
    rd("R10", 4'd6);
    wr("R10", 4'd4, 8'h45);
    peek("R10", 4'd6);
    rd("R10", 4'd6);

    // R7 FIFO fill past full, ordered drain, empty read, flush
    for (int i = 0; i < 17; i++) wr("R7", 4'd3, 8'(8'h50 + i));
    peek("R7", 4'd8);
    for (int i = 0; i < 17; i++) rd("R7", 4'd3);
    peek("R7", 4'd8);
    for (int i = 0; i < 3; i++) wr("R7", 4'd3, 8'(8'hC0 + i));
    peek("R7", 4'd8);
    wr("R7", 4'd4, 8'h01);
    peek("R7", 4'd8);
    peek("R7", 4'd3);

    // R12 handoff strobes and a non-handoff code
    wr("R12", 4'd4, 8'h10);
    wr("R12", 4'd4, 8'h91);
    wr("R12", 4'd4, 8'h41);
    peek("R12", 4'd4);
    wr("R12", 4'd4, 8'h42);
    peek("R12", 4'd4);
    wr("R12", 4'd4, 8'hC3);
    wr("R12", 4'd4, 8'h05);
    peek("R12", 4'd4);
    peek("R12", 4'd4);

    // R14 target write versus status read
    cyc("R13", 0, 0, 4'd5, 8'h00, 0, 3'd0, 1);
    wr("R14", 4'd5, 8'h06);
    peek("R14", 4'd5);

    // R11 chip reset command from a dirty state
    wr("R11", 4'd2, 8'h33);
    wr("R11", 4'd4, 8'h80);
    wr("R11", 4'd3, 8'h99);
    wr("R11", 4'd4, 8'h03);
    wr("R11", 4'd4, 8'h02);
    for (int i = 0; i < 10; i++) peek("R11", 4'(i));
    peek("R11", 4'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule